// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external asynchronous static RAM with 16-bit words. It turns one host request into one timed access on the memory pins. A request carries an address, a read or write flag, write data and a per-byte lane mask. The memory side has active-low chip select, output enable and write strobe, one active-low enable per byte lane, and a data bus split into a driven value, a drive enable and a sampled input.

The controller is clocked, and the memory has no clock. Each phase of an access therefore lasts a whole number of cycles, and those counts are worked out at elaboration from the memory's nanosecond minimums and the `CLK_PERIOD_NS` parameter. Every phase lasts at least one cycle.

A write lasts exactly as long as chip select, write strobe and at least one lane enable are all low at the same time. All of these signals rise together on one edge, which ends the write. A read holds chip select and output enable low until the access time has passed. It then captures the data, raises a one-cycle done pulse and waits out the bus-release time before the next request can be accepted.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip select, output enable, write strobe and both lane enables are high, the bus drive enable is low, done is low and ready is high.
- R2: A read holds chip select and output enable low and the write strobe high for RD_CYC = max(ceil(55/T), ceil(25/T)) cycles, where T is the clock period in ns. Done rises RD_CYC cycles after the accepting edge.
- R3: Mask bit 0 drives lane enable bit 0, which selects data bits 7:0. Mask bit 1 drives lane enable bit 1, which selects data bits 15:8. On a read, a lane that is not selected returns zero in the read data. On a write, a lane that is not selected leaves that byte of the memory unchanged.
- R4: A write holds chip select, the write strobe and the selected lane enables all low for WR_CYC = max(ceil(45/T), ceil(25/T), ceil(55/T) - 1) cycles, with output enable high. All of them rise on the same edge, and done follows WR_CYC + 1 cycles after the accepting edge.
- R5: The bus drive enable is high only during a write. It is high from the first strobe cycle until one cycle after the strobes rise, and the write data stays on the bus for that whole span.
- R6: The bus is never driven while output enable is low. After a read, output enable stays high for at least ceil(20/T) cycles before the controller can drive the bus again.
- R7: A request with mask 0 asserts no strobe at all and raises done one cycle after it is accepted.
- R8: Done lasts exactly one cycle. Ready is high only when the controller is idle and done is low. A request presented while ready is low is ignored.
- R9: The memory address stays constant for as long as chip select remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | LANES | Lane select, bit 0 = bits 7:0 |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_be_n | output | LANES | Lane enables, active low, bit 0 = lower byte |
| sram_dq_out | output | DATA_W | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
The assertions assume a synchronous reset, and they look at request fields only on the accepting edge. After that edge the controller works from its own registered copies. They also assume the memory's input data is settled by the edge at which the read is captured. The memory model in the bench makes sure of this: it returns a junk pattern until output enable and chip select have been low for the full read access count. The bench changes its inputs only on falling clock edges. It offers a second request while an access is still running, which exercises the ignore path, but it never changes a request on the cycle in which that request is accepted.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_TURN = 3'd2,
    ST_WR   = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;

  // Whole cycles covering a nanosecond minimum, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_timer.sv
module asram_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asram_lane_gate.sv
module asram_lane_gate #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_en,
  input  logic [LANES-1:0]        set_mask,
  input  logic                    clr_en,
  input  logic                    cap_en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES-1:0]        be_n,
  output logic [LANES*LANE_W-1:0] rdata
);
  logic [LANES-1:0] mask_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        be_n[i]   <= 1'b1;
        mask_q[i] <= 1'b0;
      end else if (set_en) begin
        be_n[i]   <= ~set_mask[i];
        mask_q[i] <= set_mask[i];
      end else if (clr_en) begin
        be_n[i]   <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[i*LANE_W +: LANE_W] <= '0;
      end else if (cap_en) begin
        rdata[i*LANE_W +: LANE_W] <= mask_q[i] ? din[i*LANE_W +: LANE_W] : '0;
      end
    end
  end

  // A lane enable never changes in the middle of an access.
  assert_lane_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (!set_en && !clr_en) |=> $stable(be_n));
endmodule

// File: rtl/asram_seq_fsm.sv
module asram_seq_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int CNT_W   = 4,
  parameter int RD_CYC  = 3,
  parameter int WR_CYC  = 3,
  parameter int TRN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              lane_set,
  output logic              lane_clr,
  output logic              cap_en,
  output logic              ready,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe
);
  seq_state_e state;
  logic       accept;
  logic       mask_any;

  assign ready    = (state == ST_IDLE) && !done;
  assign accept   = req_valid && ready;
  assign mask_any = |req_mask;

  assign lane_set = accept && mask_any;
  assign lane_clr = ((state == ST_RD) || (state == ST_WR)) && tmr_expired;
  assign cap_en   = (state == ST_RD) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (lane_set) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if (cap_en) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(TRN_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!mask_any) begin
              done <= 1'b1;
            end else if (req_write) begin
              addr_q  <= req_addr;
              wdata_q <= req_wdata;
              ce_n    <= 1'b0;
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              state   <= ST_WR;
            end else begin
              addr_q <= req_addr;
              ce_n   <= 1'b0;
              oe_n   <= 1'b0;
              state  <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (tmr_expired) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (tmr_expired) state <= ST_IDLE;
        end
        ST_WR: begin
          if (tmr_expired) begin
            ce_n  <= 1'b1;
            we_n  <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          dq_oe <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_oe_we_R2: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> we_n);
  assert_drive_oe_R6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !mask_any) |=> (ce_n && oe_n && we_n && done));
endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int LANES         = 2,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ACC_NS      = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_CYC_NS      = 55,
  parameter int T_WPW_NS      = 45,
  parameter int T_AW_NS       = 45,
  parameter int T_DS_NS       = 25,
  parameter int T_REL_NS      = 20,
  localparam int DATA_W       = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [LANES-1:0]  sram_be_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned P       = CLK_PERIOD_NS;
  localparam int unsigned CYC_TOT = ns_to_cyc(T_CYC_NS, P);
  localparam int          RD_CYC  = max2(ns_to_cyc(T_ACC_NS, P), ns_to_cyc(T_OE_NS, P));
  localparam int          WR_CYC  = max2(max2(ns_to_cyc(T_WPW_NS, P), ns_to_cyc(T_AW_NS, P)),
                                         max2(ns_to_cyc(T_DS_NS, P), (CYC_TOT > 1) ? CYC_TOT - 1 : 1));
  localparam int          TRN_CYC = max2(ns_to_cyc(T_REL_NS, P),
                                         (CYC_TOT > RD_CYC) ? CYC_TOT - RD_CYC : 1);
  localparam int          MAX_CYC = max2(max2(RD_CYC, WR_CYC), TRN_CYC);
  localparam int          CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             lane_set;
  logic             lane_clr;
  logic             cap_en;

  asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_seq_fsm #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES), .CNT_W (CNT_W),
    .RD_CYC (RD_CYC), .WR_CYC (WR_CYC), .TRN_CYC (TRN_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_mask    (req_mask),
    .req_wdata   (req_wdata),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .lane_set    (lane_set),
    .lane_clr    (lane_clr),
    .cap_en      (cap_en),
    .ready       (req_ready),
    .done        (rsp_done),
    .addr_q      (sram_addr),
    .wdata_q     (sram_dq_out),
    .ce_n        (sram_ce_n),
    .oe_n        (sram_oe_n),
    .we_n        (sram_we_n),
    .dq_oe       (sram_dq_oe)
  );

  asram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .set_en   (lane_set),
    .set_mask (req_mask),
    .clr_en   (lane_clr),
    .cap_en   (cap_en),
    .din      (sram_dq_in),
    .be_n     (sram_be_n),
    .rdata    (rsp_rdata)
  );

  assert_lane_ce_R3: assert property (@(posedge clk) disable iff (rst)
    (sram_be_n != '1) |-> !sram_ce_n);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  assert_wr_release_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (sram_ce_n && (sram_be_n == '1) && sram_dq_oe));
endmodule

// File: tb/asram_lane_ctrl_bench.sv
module asram_lane_ctrl_bench;
  localparam int PER     = 20;
  localparam int RD_NEED = (55 + PER - 1) / PER;
  localparam int WR_NEED = (45 + PER - 1) / PER;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [1:0]  mask;
    logic [15:0] wdata;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0010, 2'b11, 16'h1234, 16'h0000},
    '{1'b0, 16'h0010, 2'b11, 16'h0000, 16'h1234},
    '{1'b1, 16'h0010, 2'b01, 16'hABCD, 16'h0000},
    '{1'b0, 16'h0010, 2'b11, 16'h0000, 16'h12CD},
    '{1'b1, 16'h0010, 2'b10, 16'hEF00, 16'h0000},
    '{1'b0, 16'h0010, 2'b11, 16'h0000, 16'hEFCD},
    '{1'b0, 16'h0010, 2'b01, 16'h0000, 16'h00CD},
    '{1'b0, 16'h0010, 2'b10, 16'h0000, 16'hEF00},
    '{1'b1, 16'h00FF, 2'b11, 16'h5555, 16'h0000},
    '{1'b0, 16'h00FF, 2'b11, 16'h0000, 16'h5555},
    '{1'b0, 16'h0010, 2'b11, 16'h0000, 16'hEFCD}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_done, ce_n, oe_n, we_n, dq_oe;
  logic [15:0] rsp_rdata, sram_addr, dq_out, dq_in;
  logic [1:0]  be_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;

  asram_lane_ctrl u_asram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_be_n(be_n), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
  );

  // Memory model, evaluated on falling edges.
  logic [15:0] mem [256];
  int rcnt = 0, wcnt = 0, oe_hi = 0;
  logic [1:0]  w_lanes = '0;
  logic [15:0] w_data = '0;
  logic [7:0]  w_addr = '0;
  logic rwin, wwin;
  int model_err_r4 = 0, model_err_r5 = 0, model_err_r6 = 0;

  assign rwin  = !ce_n && !oe_n && we_n;
  assign wwin  = !ce_n && !we_n && (be_n != 2'b11);
  assign dq_in = (rwin && rcnt >= RD_NEED) ? mem[sram_addr[7:0]] : 16'hA5A5;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (dq_oe && (!oe_n || oe_hi < 1)) model_err_r6++;
      if (dq_oe && !wwin && wcnt == 0) model_err_r5++;
      oe_hi <= oe_n ? oe_hi + 1 : 0;
      rcnt  <= rwin ? rcnt + 1 : 0;
      if (wwin) begin
        if (!dq_oe || !oe_n) model_err_r5++;
        wcnt    <= wcnt + 1;
        w_lanes <= ~be_n;
        w_data  <= dq_out;
        w_addr  <= sram_addr[7:0];
      end else if (wcnt > 0) begin
        if (!dq_oe || dq_out != w_data) model_err_r5++;
        if (wcnt < WR_NEED) model_err_r4++;
        if (w_lanes[0]) mem[w_addr][7:0]  <= w_data[7:0];
        if (w_lanes[1]) mem[w_addr][15:8] <= w_data[15:8];
        wcnt <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic w, input logic [15:0] a, input logic [1:0] m,
                     input logic [15:0] d, output logic [15:0] rd,
                     output int lat, output int ce_cyc, output int bad_lane, output int bad_addr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_mask = m; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; ce_cyc = 0; bad_lane = 0; bad_addr = 0;
    while (!rsp_done && lat < 40) begin
      if (!ce_n) begin
        ce_cyc++;
        if (be_n != ~m) bad_lane++;
        if (sram_addr != a) bad_addr++;
      end
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  initial begin
    logic [15:0] rd;
    int lat, cec, bl, ba;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ce_n && oe_n && we_n, "R1 strobes", {29'd0, ce_n, oe_n, we_n}, 32'h7);
    chk(be_n == 2'b11 && !dq_oe, "R1 lanes/drive", {29'd0, dq_oe, be_n}, 32'h3);
    chk(!rsp_done && req_ready, "R1 done/ready", {30'd0, rsp_done, req_ready}, 32'h1);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(ce_n && req_ready && !rsp_done, "R1 after release", {29'd0, ce_n, req_ready, rsp_done}, 32'h6);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      txn(VECS[i].wr, VECS[i].addr, VECS[i].mask, VECS[i].wdata, rd, lat, cec, bl, ba);
      if (VECS[i].wr) begin
        chk(lat == WR_NEED + 2, "R4 write done latency", lat, WR_NEED + 2);
      end else begin
        chk(lat == RD_NEED + 1, "R2 read done latency", lat, RD_NEED + 1);
        chk(rd == VECS[i].exp, "R3 read data by lane", {16'd0, rd}, {16'd0, VECS[i].exp});
      end
      chk(bl == 0, "R3 lane enables follow mask", bl, 0);
      chk(ba == 0, "R9 address steady", ba, 0);
    end
    chk(model_err_r4 == 0, "R4 write window width", model_err_r4, 0);
    chk(model_err_r5 == 0, "R5 bus drive span", model_err_r5, 0);
    chk(model_err_r6 == 0, "R6 bus turnaround", model_err_r6, 0);

    // R7: empty mask
    txn(1'b1, 16'h0010, 2'b00, 16'h0000, rd, lat, cec, bl, ba);
    chk(lat == 1, "R7 empty mask done", lat, 1);
    chk(cec == 0, "R7 no strobe", cec, 0);
    @(negedge clk);
    chk(!rsp_done, "R8 done single cycle", {31'd0, rsp_done}, 0);
    txn(1'b0, 16'h0010, 2'b11, 16'h0000, rd, lat, cec, bl, ba);
    chk(rd == 16'hEFCD, "R7 empty write left memory", {16'd0, rd}, 32'hEFCD);

    // R8: request while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0010; req_mask = 2'b11;
    @(negedge clk);
    chk(!req_ready, "R8 busy not ready", {31'd0, req_ready}, 0);
    req_write = 1'b1; req_wdata = 16'h0000;
    begin
      int we_seen = 0;
      for (int k = 0; k < 3; k++) begin
        if (!we_n) we_seen++;
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(we_seen == 0, "R8 busy request ignored", we_seen, 0);
    end
    repeat (4) @(negedge clk);
    chk(we_n && req_ready, "R8 idle again", {30'd0, we_n, req_ready}, 32'h3);
    txn(1'b0, 16'h0010, 2'b11, 16'h0000, rd, lat, cec, bl, ba);
    chk(rd == 16'hEFCD, "R8 memory untouched", {16'd0, rd}, 32'hEFCD);

    // R6: write right after read
    txn(1'b1, 16'h0020, 2'b11, 16'hBEEF, rd, lat, cec, bl, ba);
    txn(1'b0, 16'h0020, 2'b11, 16'h0000, rd, lat, cec, bl, ba);
    chk(rd == 16'hBEEF, "R6 read after write", {16'd0, rd}, 32'hBEEF);
    chk(model_err_r6 == 0, "R6 no contention", model_err_r6, 0);
    chk(model_err_r5 == 0, "R5 drive held", model_err_r5, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule